// File: doc/BRIEF.md
# Bus Clock Divider Pair Search

This block works out the two counter settings that a serial two-wire bus controller uses to derive its bus clock from a source clock. The bus frequency is `f_src / (2 * S * T)`, where S is the sample count (1 to 8) and T is the step count. For a requested bus speed, the engine looks for the pair (S, T) whose product is the smallest one that keeps the bus at or below the request. It returns both counts minus one, in the form a timing register holds, and raises a flag when even the slowest allowed pair is still too fast.

Software or a configuration sequencer places the source rate and the target rate in hertz on the inputs and pulses `start`. The engine first clamps the target. It then chooses the step ceiling that goes with the speed class and forms the ideal divisor. Next it walks the sample counts upward, and a final division checks the result against the target. All divisions go through one shared shift-and-subtract divider, so a result takes several hundred cycles. `done` marks the cycle in which the result appears, and the outputs hold that result until the next search finishes.

The controller steps through six named states. IDLE waits for `start`: a bad input goes straight to FINISH, and anything else goes to OPTDIV. OPTDIV forms the ideal divisor and then moves to STEPDIV. STEPDIV divides the divisor by the current sample count and then moves to EVAL. EVAL scores the candidate. It goes to CHECK on an exact hit or after the last sample count, and otherwise returns to STEPDIV with the next count. CHECK computes the resulting bus frequency and then moves to FINISH. FINISH pulses `done` and returns to IDLE.

Top module: `clkdiv_pair_search`

## Requirements
- R1: A target above 3,400,000 Hz is treated as exactly 3,400,000 Hz in every later step, including the final speed check.
- R2: The step ceiling is 8 when the clamped target is above 400,000 Hz and 64 otherwise, so a target of exactly 400,000 Hz uses the ceiling of 64.
- R3: The ideal divisor D is ceil(floor(f_src/2) / target). For each sample count s from 1 to 8, the candidate step is ceil(D/s), and a candidate whose step exceeds the ceiling is discarded.
- R4: The chosen pair is the surviving candidate with the smallest product s*step. A later candidate replaces the held one only when its product is strictly smaller, so on a tie the lower sample count is kept.
- R5: When a new best product equals D, the search stops without trying higher sample counts, which gives a shorter start-to-done latency than a full walk.
- R6: When no candidate survives, the pair defaults to sample count 8 and step equal to the ceiling.
- R7: `err` is 1 when floor(f_src / (2*S*T)) for the chosen pair is greater than the clamped target, and 0 otherwise.
- R8: `sample_code` equals S-1 (3 bits) and `step_code` equals T-1 (6 bits).
- R9: `done` is high for exactly one cycle per search and `busy` is high from the cycle after `start` until that cycle. The three result outputs keep their values until the next `done`.
- R10: A `start` pulse that arrives while `busy` is high is ignored: no second search starts and the running one finishes with its own inputs.
- R11: A target of 0 or a source rate below 2 Hz sets `err` to 1, gives the default codes of R6 without searching, and still produces a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search, sampled only while idle |
| src_hz | input | 32 | Source clock rate in Hz |
| target_hz | input | 32 | Requested bus rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| sample_code | output | 3 | Chosen sample count minus one |
| step_code | output | 6 | Chosen step count minus one |
| err | output | 1 | Requested speed cannot be reached |

## Verification
The bench builds the engine with its default parameters: 32-bit rates, eight sample counts, step ceilings of 64 and 8, a 3.4 MHz clamp and a 400 kHz class threshold. With these values, source clocks in the tens of MHz reach the clamp, the exact class boundary, a product tie between sample counts 3 and 6, and the no-candidate default. With a 32-bit divider, an early exit at the first sample count saves seven divisions, and that gap is large enough to measure at the ports.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPTDIV,
        ST_STEPDIV,
        ST_EVAL,
        ST_CHECK,
        ST_FINISH
    } srch_state_t;

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] ceil_q
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt_r;
    logic          run_r, done_r;
    logic [W:0]    trial, diff;
    logic          fits;

    always_comb begin
        trial = {r_r, q_r[W-1]};
        diff  = trial - {1'b0, d_r};
        fits  = trial >= {1'b0, d_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r    <= '0;
            r_r    <= '0;
            d_r    <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (go) begin
                q_r   <= num;
                r_r   <= '0;
                d_r   <= den;
                cnt_r <= CW'(W);
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[W-2:0], fits};
                r_r   <= fits ? diff[W-1:0] : trial[W-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    run_r  <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done   = done_r;
    assign quot   = q_r;
    assign ceil_q = q_r + W'(r_r != '0);

    // R3
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> (r_r < d_r));

endmodule

// File: rtl/cand_score.sv
module cand_score #(
    parameter int W  = 32,
    parameter int SW = 4,
    parameter int TW = 7,
    parameter int PW = W + SW
) (
    input  logic [W-1:0]  step,
    input  logic [SW-1:0] smp,
    input  logic [TW-1:0] lim,
    input  logic [PW-1:0] best,
    input  logic [W-1:0]  opt,
    output logic          take,
    output logic          exact
);
    logic [PW-1:0] prod;

    always_comb begin
        prod  = PW'(step) * PW'(smp);
        take  = (step <= W'(lim)) && (prod < best);
        exact = (prod == PW'(opt));
    end

endmodule

// File: rtl/clkdiv_pair_search.sv
module clkdiv_pair_search
    import clkdiv_search_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SAMPLE_MAX  = 8,
    parameter int STEP_LIM_LO = 64,
    parameter int STEP_LIM_HI = 8,
    parameter int CLAMP_HZ    = 3400000,
    parameter int FAST_HZ     = 400000,
    localparam int SCW = $clog2(SAMPLE_MAX),
    localparam int TCW = $clog2(STEP_LIM_LO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_hz,
    input  logic [DATA_W-1:0] target_hz,
    output logic              busy,
    output logic              done,
    output logic [SCW-1:0]    sample_code,
    output logic [TCW-1:0]    step_code,
    output logic              err
);
    localparam int SW = $clog2(SAMPLE_MAX + 1);
    localparam int TW = $clog2(STEP_LIM_LO + 1);
    localparam int PW = DATA_W + SW;

    srch_state_t state, nxt;

    logic [DATA_W-1:0] src_r, tgt_r, opt_r, step_r;
    logic [TW-1:0]     lim_r, best_step;
    logic [SW-1:0]     s_r, best_s;
    logic [PW-1:0]     best_prod;
    logic              dv_go, dv_done;
    logic [DATA_W-1:0] dv_num, dv_den, dv_quot, dv_ceil;
    logic              ev_take, ev_exact, ev_stop;

    logic [DATA_W-1:0] tclamp, chk_den;
    logic [TW-1:0]     lim_in;
    logic              bad_in;

    always_comb begin
        tclamp  = (target_hz > DATA_W'(CLAMP_HZ)) ? DATA_W'(CLAMP_HZ) : target_hz;
        lim_in  = (tclamp > DATA_W'(FAST_HZ)) ? TW'(STEP_LIM_HI) : TW'(STEP_LIM_LO);
        bad_in  = (target_hz == '0) || (src_hz < DATA_W'(2));
        ev_stop = (ev_take && ev_exact) || (s_r == SW'(SAMPLE_MAX));
        chk_den = ev_take ? DATA_W'(2) * DATA_W'(s_r) * DATA_W'(step_r[TW-1:0])
                          : DATA_W'(2) * DATA_W'(best_s) * DATA_W'(best_step);
    end

    seq_divider #(.W(DATA_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (dv_go),
        .num    (dv_num),
        .den    (dv_den),
        .done   (dv_done),
        .quot   (dv_quot),
        .ceil_q (dv_ceil)
    );

    cand_score #(.W(DATA_W), .SW(SW), .TW(TW), .PW(PW)) u_score (
        .step  (step_r),
        .smp   (s_r),
        .lim   (lim_r),
        .best  (best_prod),
        .opt   (opt_r),
        .take  (ev_take),
        .exact (ev_exact)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)   nxt = bad_in ? ST_FINISH : ST_OPTDIV;
            ST_OPTDIV:  if (dv_done) nxt = ST_STEPDIV;
            ST_STEPDIV: if (dv_done) nxt = ST_EVAL;
            ST_EVAL:    nxt = ev_stop ? ST_CHECK : ST_STEPDIV;
            ST_CHECK:   if (dv_done) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_r <= '0; tgt_r <= '0; opt_r <= '0; step_r <= '0;
            lim_r <= '0; best_step <= '0; s_r <= '0; best_s <= '0;
            best_prod <= '0; dv_go <= 1'b0; dv_num <= '0; dv_den <= '0;
            sample_code <= '0; step_code <= '0; err <= 1'b0;
        end else begin
            dv_go <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    src_r     <= src_hz;
                    tgt_r     <= tclamp;
                    lim_r     <= lim_in;
                    best_prod <= PW'(SAMPLE_MAX) * PW'(lim_in);
                    best_s    <= SW'(SAMPLE_MAX);
                    best_step <= lim_in;
                    if (bad_in) begin
                        err         <= 1'b1;
                        sample_code <= SCW'(SAMPLE_MAX - 1);
                        step_code   <= TCW'(lim_in - 1'b1);
                    end else begin
                        dv_go  <= 1'b1;
                        dv_num <= src_hz >> 1;
                        dv_den <= tclamp;
                    end
                end
                ST_OPTDIV: if (dv_done) begin
                    opt_r  <= dv_ceil;
                    s_r    <= SW'(1);
                    dv_go  <= 1'b1;
                    dv_num <= dv_ceil;
                    dv_den <= DATA_W'(1);
                end
                ST_STEPDIV: if (dv_done) step_r <= dv_ceil;
                ST_EVAL: begin
                    if (ev_take) begin
                        best_prod <= PW'(step_r) * PW'(s_r);
                        best_s    <= s_r;
                        best_step <= step_r[TW-1:0];
                    end
                    dv_go <= 1'b1;
                    if (ev_stop) begin
                        dv_num <= src_r;
                        dv_den <= chk_den;
                    end else begin
                        s_r    <= s_r + 1'b1;
                        dv_num <= opt_r;
                        dv_den <= DATA_W'(s_r + 1'b1);
                    end
                end
                ST_CHECK: if (dv_done) begin
                    err         <= dv_quot > tgt_r;
                    sample_code <= SCW'(best_s - 1'b1);
                    step_code   <= TCW'(best_step - 1'b1);
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sample_code) && $stable(step_code) && $stable(err)));
    // R2
    step_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> (best_step <= lim_r));

endmodule

// File: tb/clkdiv_pair_search_bench.sv
module clkdiv_pair_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_hz = '0;
    logic [31:0] target_hz = '0;
    logic        busy, done, err;
    logic [2:0]  sample_code;
    logic [5:0]  step_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clkdiv_pair_search u_clkdiv_pair_search (
        .clk(clk), .rst_n(rst_n), .start(start), .src_hz(src_hz),
        .target_hz(target_hz), .busy(busy), .done(done),
        .sample_code(sample_code), .step_code(step_code), .err(err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference from the requirements
    task automatic model(input longint c, input longint t,
                         output int es, output int et, output int ee);
        longint tc, mx, opt, best, st;
        tc = (t > 3400000) ? 3400000 : t;
        mx = (tc > 400000) ? 8 : 64;
        es = 7; et = int'(mx) - 1;
        if (t == 0 || c < 2) begin ee = 1; return; end
        opt = ((c / 2) + tc - 1) / tc;
        best = 8 * mx;
        begin
            longint bs, bt;
            bs = 8; bt = mx;
            for (int s = 1; s <= 8; s++) begin
                st = (opt + s - 1) / s;
                if (st > mx) continue;
                if (st * s < best) begin
                    best = st * s; bs = s; bt = st;
                    if (best == opt) break;
                end
            end
            es = int'(bs) - 1; et = int'(bt) - 1;
            ee = ((c / (2 * bs * bt)) > tc) ? 1 : 0;
        end
    endtask

    task automatic run(input longint c, input longint t, output int cyc);
        @(negedge clk);
        src_hz = 32'(c); target_hz = 32'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        if (!done) chk("R9 watchdog", 0, 1);
    endtask

    task automatic run_cmp(input string req, input longint c, input longint t);
        int es, et, ee, cyc;
        model(c, t, es, et, ee);
        run(c, t, cyc);
        chk({req, " sample"}, sample_code, es);
        chk({req, " step"}, step_code, et);
        chk({req, " err"}, err, ee);
    endtask

    task automatic t_reset;
        chk("R9 reset busy", busy, 0);
        chk("R9 reset done", done, 0);
        chk("R8 reset codes", {sample_code, step_code, err}, 0);
    endtask

    task automatic t_exact;
        // R3 R8: D=40, s=1 step 40 -> codes 0,39
        int cyc;
        run(8000000, 100000, cyc);
        chk("R8 exact sample", sample_code, 0);
        chk("R8 exact step", step_code, 39);
        chk("R7 exact err", err, 0);
    endtask

    task automatic t_tie;
        // R4: D=17, ceiling 8; s=3 and s=6 both give 18, keep s=3
        int cyc;
        run(34000000, 1000000, cyc);
        chk("R4 tie sample", sample_code, 2);
        chk("R4 tie step", step_code, 5);
        chk("R7 tie err", err, 0);
    endtask

    task automatic t_clamp;
        // R1: 5 MHz -> 3.4 MHz, D=10, s=2 step 5
        int cyc;
        run(68000000, 5000000, cyc);
        chk("R1 clamp sample", sample_code, 1);
        chk("R1 clamp step", step_code, 4);
        chk("R1 clamp err", err, 0);
    endtask

    task automatic t_mode_edge;
        int cyc;
        run(32000000, 400000, cyc);
        chk("R2 edge 400k sample", sample_code, 0);
        chk("R2 edge 400k step", step_code, 39);
        run(32000000, 400001, cyc);
        chk("R2 edge 400001 sample", sample_code, 4);
        chk("R2 edge 400001 step", step_code, 7);
    endtask

    task automatic t_default;
        // R6 R7: D=50000 too large, defaults 8 and 64, still too fast
        int cyc;
        run(100000000, 1000, cyc);
        chk("R6 default sample", sample_code, 7);
        chk("R6 default step", step_code, 63);
        chk("R7 unsupported err", err, 1);
    endtask

    task automatic t_bad;
        int cyc;
        run(50000000, 0, cyc);
        chk("R11 zero target err", err, 1);
        chk("R11 zero target codes", {sample_code, step_code}, {3'd7, 6'd63});
        run(1, 1000000, cyc);
        chk("R11 low source err", err, 1);
        chk("R11 low source codes", {sample_code, step_code}, {3'd7, 6'd7});
    endtask

    task automatic t_early;
        int c_early, c_full;
        run(8000000, 100000, c_early);
        run(34000000, 1000000, c_full);
        chk("R5 early exit shorter", (c_early < c_full) ? 1 : 0, 1);
    endtask

    task automatic t_busy_start;
        int cyc, seen;
        @(negedge clk);
        src_hz = 32'd34000000; target_hz = 32'd1000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 busy during run", busy, 1);
        src_hz = 32'd8000000; target_hz = 32'd100000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        chk("R10 first result sample", sample_code, 2);
        chk("R10 first result step", step_code, 5);
        seen = 0;
        repeat (600) begin @(negedge clk); if (done || busy) seen = 1; end
        chk("R10 no second search", seen, 0);
        chk("R9 results held", {sample_code, step_code}, {3'd2, 6'd5});
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 10; i++) begin
            run_cmp("R3 sweep", 26000000 + longint'(i) * 3700001,
                    50000 + longint'(i) * 411111);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_tie();
        t_clamp();
        t_mode_edge();
        t_default();
        t_bad();
        t_early();
        t_busy_start();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule